// File: doc/BRIEF.md
# Selectable-Cutoff DC-Blocking Highpass

This block removes the DC and very-low-frequency content from a 16-bit signed audio stream sampled at 40 kHz. It is a first-order recursive highpass, y[n] = x[n] - x[n-1] + a*y[n-1]. The multiply by the pole coefficient `a` is replaced with a subtract-and-shift of the feedback state. A 2-bit select input chooses the cutoff: roughly 50 Hz, roughly 100 Hz, or a bypass that passes samples through untouched.

Samples arrive with a one-cycle valid strobe. Each accepted sample produces one registered output sample one clock later, also with a valid strobe. The feedback state keeps extra fractional bits below the output LSB, so the output settles cleanly to zero instead of stalling in a small limit cycle. A change of the select value takes effect at the next accepted sample, and that sample also zeroes the filter history. The output and the stored state are clamped to the signed 16-bit range.

Top module: `hp_dc_block`

## Requirements
- R1: While rst_ni is low and after its release until the first accepted sample, out_valid_o is 0 and out_data_o is 0.
- R2: out_valid_o is 1 in exactly the cycle after each cycle with in_valid_i high, and 0 otherwise.
- R3: cut_sel_i = 2'b00 and 2'b11 select bypass: the output sample equals the input sample exactly.
- R4: cut_sel_i = 2'b01 selects the ~50 Hz cutoff. The pole is a = 1 - 2^-7 (Q1.15 value 32512). The state s holds the output with 8 extra fractional bits, and s[n] = 256*(x[n] - x[n-1]) + s[n-1] - floor(s[n-1]/128). The output is floor(s[n]/256).
- R5: cut_sel_i = 2'b10 selects the ~100 Hz cutoff. The recursion is the same as in R4, with a = 1 - 2^-6 (Q1.15 value 32256) and floor(s[n-1]/64) as the decay term.
- R6: When an accepted sample carries a select value that differs from the one carried by the previous accepted sample (reset counts as 2'b00), the filter history is zeroed first. An in-range input then comes out unchanged on that sample.
- R7: The state s is clamped to [-32768*256, 32767*256+255] before it is stored and used. An overflowing result therefore gives out_data_o = -32768 or 32767.
- R8: out_data_o holds its value in every cycle after a cycle with in_valid_i low.
- R9: With cutoff 2'b01 and a constant positive input held for 2000 samples, the output reaches exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cut_sel_i | input | 2 | Cutoff select: 00/11 bypass, 01 ~50 Hz, 10 ~100 Hz |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 16 | Signed input sample |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | 16 | Signed filtered sample |

## Verification
Every result is due exactly one clock after the edge that accepts its input, because the output, its strobe and the state all sit behind a single register stage. The bench drives inputs on the falling edge and lets one rising edge pass. It then reads out_data_o and out_valid_o on the following falling edge. One further idle cycle confirms that the strobe dropped and the data held. The hand-worked recursion values in the vector table build on one another, so the table is walked in order with no reset in between. The decay check reads only the last of 2000 back-to-back outputs.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  typedef enum logic [1:0] {
    CUT_BYPASS  = 2'b00,
    CUT_LOW     = 2'b01,
    CUT_HIGH    = 2'b10,
    CUT_BYPASS2 = 2'b11
  } cut_sel_e;
endpackage

// File: rtl/hpf_cut_decode.sv
module hpf_cut_decode
  import hpf_pkg::*;
#(
  parameter int SH_W     = 4,
  parameter int SHIFT_LO = 7,
  parameter int SHIFT_HI = 6
) (
  input  logic [1:0]      sel_i,
  output logic            bypass_o,
  output logic [SH_W-1:0] shift_o
);
  always_comb begin
    bypass_o = 1'b0;
    shift_o  = SH_W'(SHIFT_LO);
    unique case (cut_sel_e'(sel_i))
      CUT_LOW:  shift_o  = SH_W'(SHIFT_LO);
      CUT_HIGH: shift_o  = SH_W'(SHIFT_HI);
      default:  bypass_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/hpf_leak_dp.sv
module hpf_leak_dp #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  parameter int SH_W   = 4,
  parameter int ACC_W  = DATA_W + FRAC_W
) (
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] xp_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  input  logic [SH_W-1:0]          shift_i,
  output logic signed [ACC_W-1:0]  acc_o
);
  localparam int EXT_W = ACC_W + 3;
  localparam int TOP_W = EXT_W - ACC_W;

  logic signed [EXT_W-1:0] diff, acc_x, leak, sum;
  logic                    ovf_pos, ovf_neg;

  always_comb begin
    diff  = {{(EXT_W-DATA_W){x_i[DATA_W-1]}}, x_i}
          - {{(EXT_W-DATA_W){xp_i[DATA_W-1]}}, xp_i};
    acc_x = {{(EXT_W-ACC_W){acc_i[ACC_W-1]}}, acc_i};
    leak  = acc_x >>> shift_i;
    sum   = (diff <<< FRAC_W) + acc_x - leak;
    // top bits above the ACC_W sign must all match the sign
    ovf_pos = !sum[EXT_W-1] && (|sum[EXT_W-2:ACC_W-1]);
    ovf_neg =  sum[EXT_W-1] && !(&sum[EXT_W-2:ACC_W-1]);
    if (ovf_pos)      acc_o = {1'b0, {(ACC_W-1){1'b1}}};
    else if (ovf_neg) acc_o = {1'b1, {(ACC_W-1){1'b0}}};
    else              acc_o = sum[ACC_W-1:0];
  end

  logic unused_top;
  assign unused_top = ^sum[EXT_W-1:EXT_W-TOP_W];
endmodule

// File: rtl/hp_dc_block.sv
module hp_dc_block
  import hpf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int SHIFT_LO = 7,
  parameter int SHIFT_HI = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cut_sel_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int ACC_W = DATA_W + FRAC_W;
  localparam int SH_W  = $clog2(ACC_W + 1);

  logic [1:0]               sel_q;
  logic signed [DATA_W-1:0] xp_q, xp_eff;
  logic signed [ACC_W-1:0]  acc_q, acc_eff, acc_nxt;
  logic                     vld_q;
  logic [DATA_W-1:0]        y_q;
  logic                     bypass, clear;
  logic [SH_W-1:0]          shift;

  hpf_cut_decode #(
    .SH_W(SH_W), .SHIFT_LO(SHIFT_LO), .SHIFT_HI(SHIFT_HI)
  ) u_dec (
    .sel_i(cut_sel_i), .bypass_o(bypass), .shift_o(shift)
  );

  // select change zeroes the history for this very sample
  assign clear   = (cut_sel_i != sel_q);
  assign xp_eff  = clear ? '0 : xp_q;
  assign acc_eff = clear ? '0 : acc_q;

  hpf_leak_dp #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .SH_W(SH_W), .ACC_W(ACC_W)
  ) u_dp (
    .x_i(in_data_i), .xp_i(xp_eff), .acc_i(acc_eff),
    .shift_i(shift), .acc_o(acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= CUT_BYPASS;
      xp_q  <= '0;
      acc_q <= '0;
      vld_q <= 1'b0;
      y_q   <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) begin
        sel_q <= cut_sel_i;
        if (bypass) begin
          xp_q  <= '0;
          acc_q <= '0;
          y_q   <= in_data_i;
        end else begin
          xp_q  <= in_data_i;
          acc_q <= acc_nxt;
          y_q   <= acc_nxt[ACC_W-1:FRAC_W];
        end
      end
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = y_q;
endmodule

// File: rtl/hp_dc_block_chk.sv
module hp_dc_block_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        cut_sel_i,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r3_bypass_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (cut_sel_i == 2'b00 || cut_sel_i == 2'b11)
    |=> out_data_o == $past(in_data_i));

  a_r6_clear_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && in_valid_i && $past(in_valid_i) && (cut_sel_i != $past(cut_sel_i))
    |=> out_data_o == $past(in_data_i));

  a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && !in_valid_i |=> $stable(out_data_o));
endmodule

bind hp_dc_block hp_dc_block_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cut_sel_i(cut_sel_i),
  .in_valid_i(in_valid_i), .in_data_i(in_data_i),
  .out_valid_o(out_valid_o), .out_data_o(out_data_o)
);

// File: tb/tb_hp_dc_block.sv
module tb_hp_dc_block;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]          req;
    logic [1:0]          sel;
    logic signed [15:0]  x;
    logic signed [15:0]  y;
  } vec_t;

  // walked in order: recursion state carries from row to row
  localparam vec_t VEC [14] = '{
    '{4'd3, 2'b00,  16'sd1234,   16'sd1234},  // R3 bypass
    '{4'd3, 2'b00, -16'sd500,   -16'sd500},   // R3 bypass
    '{4'd6, 2'b01,  16'sd1000,   16'sd1000},  // R6 change clears
    '{4'd4, 2'b01,  16'sd1000,   16'sd992},   // R4
    '{4'd4, 2'b01,  16'sd1000,   16'sd984},   // R4
    '{4'd4, 2'b01,  16'sd0,     -16'sd24},    // R4 floor of negative
    '{4'd6, 2'b10,  16'sd2000,   16'sd2000},  // R6 change clears
    '{4'd5, 2'b10,  16'sd2000,   16'sd1968},  // R5
    '{4'd5, 2'b10,  16'sd2000,   16'sd1937},  // R5
    '{4'd7, 2'b10, -16'sd32768, -16'sd32768}, // R7 negative clamp
    '{4'd7, 2'b10,  16'sd32767,  16'sd32767}, // R7 positive clamp
    '{4'd3, 2'b11, -16'sd7,     -16'sd7},     // R3 second bypass code
    '{4'd3, 2'b11,  16'sd32767,  16'sd32767}, // R3
    '{4'd3, 2'b11, -16'sd32768, -16'sd32768}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cut_sel_i = 2'b00;
  logic        in_valid_i = 1'b0;
  logic [15:0] in_data_i = '0;
  logic        out_valid_o;
  logic [15:0] out_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_dc_block dut (
    .clk_i(clk), .rst_ni(rst_ni), .cut_sel_i(cut_sel_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one sample, return the output due one edge later
  task automatic send(input logic [1:0] sel, input logic signed [15:0] x,
                      output logic signed [15:0] y, output logic v);
    @(negedge clk);
    cut_sel_i  = sel;
    in_data_i  = x;
    in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    y = out_data_o;
    v = out_valid_o;
  endtask

  initial begin
    logic signed [15:0] y;
    logic               v;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(out_valid_o), 0);
    check("R1 reset data", int'(out_data_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle valid", int'(out_valid_o), 0);
    check("R1 idle data", int'(out_data_o), 0);

    for (int i = 0; i < 14; i++) begin
      logic signed [15:0] held;
      send(VEC[i].sel, VEC[i].x, y, v);
      check($sformatf("R%0d vec %0d", VEC[i].req, i), int'(y), int'(VEC[i].y));
      check("R2 valid one cycle later", int'(v), 1);
      held = y;
      @(negedge clk);
      check("R2 valid drops", int'(out_valid_o), 0);
      check("R8 data held", int'($signed(out_data_o)), int'(held));
    end

    // R9: constant input decays to zero with the 50 Hz pole
    send(2'b01, 16'sd4000, y, v);
    check("R6 clear before decay", int'(y), 4000);
    for (int n = 1; n < 2000; n++) begin
      @(negedge clk);
      cut_sel_i  = 2'b01;
      in_data_i  = 16'sd4000;
      in_valid_i = 1'b1;
    end
    @(negedge clk);
    in_valid_i = 1'b0;
    check("R9 decayed output", int'($signed(out_data_o)), 0);

    // R6: change during idle takes effect at the next accepted sample
    cut_sel_i = 2'b10;
    repeat (3) @(negedge clk);
    check("R8 idle select change holds", int'($signed(out_data_o)), 0);
    send(2'b10, 16'sd4000, y, v);
    check("R6 clear after idle change", int'(y), 4000);

    // R1: mid-run reset
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run data", int'(out_data_o), 0);
    check("R1 reset mid-run valid", int'(out_valid_o), 0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule